// File: doc/BRIEF.md
# Decoupled Fetch Address Queue with Prefetch Lookahead

This block sits between a branch predictor and an instruction cache. The predictor pushes predicted fetch-block addresses into a circular queue. The cache pulls them in order as demand fetches. Because the queue buffers predictions, the predictor keeps running while the cache is stalled on a miss. It only stops when the queue has no free slot.

A second read pointer, the lookahead pointer, walks the queued addresses ahead of the demand pointer. While the cache reports an outstanding miss, the lookahead port offers those future addresses to a prefetch engine. The prefetch engine consumes them independently of demand dequeues. The lookahead pointer never passes the write pointer. When demand dequeues overtake it, it jumps forward to the demand pointer.

A redirect flush empties the queue in one cycle and returns all three pointers to a common origin. `DEPTH` must be a power of two.

Top module: `decoupled_fetch_queue`

## Requirements
- R1: After reset the queue is empty: `enq_ready_o` is 1, `deq_valid_o` is 0 and `pf_valid_o` is 0, even with `miss_pending_i` high.
- R2: Addresses leave the demand port in the order they were accepted. An entry is removed in a cycle where `deq_valid_o` and `deq_ready_i` are both 1. `deq_valid_o` is 1 exactly when at least one entry is held.
- R3: The queue holds at most `DEPTH` entries (default 16). `enq_ready_o` is 0 while `DEPTH` entries are held. An enqueue offered while full is dropped and stores nothing.
- R4: An enqueue is accepted whenever `enq_valid_i` and `enq_ready_o` are 1 and no flush is requested, regardless of `deq_ready_i` and `miss_pending_i`.
- R5: `pf_valid_o` is 1 only while `miss_pending_i` is 1 and the lookahead pointer is behind the write pointer. `pf_addr_o` then shows the entry at the lookahead pointer.
- R6: The lookahead pointer advances by one on each cycle with `pf_valid_o` and `pf_ready_i` both 1, whether or not a demand dequeue happens. It never moves past the write pointer.
- R7: When a demand dequeue leaves the lookahead pointer behind the demand pointer, the lookahead pointer moves to the demand pointer. The next lookahead address equals the next demand address.
- R8: `flush_i` empties the queue on the next cycle and sets the write, demand and lookahead pointers equal. It overrides an enqueue or dequeue offered in the same cycle; the enqueued address is never stored.
- R9: While `deq_valid_o` is 1 and `deq_ready_i` is 0 with no flush, `deq_addr_o` and `deq_valid_o` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Redirect: discard all queued addresses |
| enq_valid_i | input | 1 | Predictor offers an address |
| enq_addr_i | input | ADDR_W | Predicted fetch-block address |
| enq_ready_o | output | 1 | Queue has a free slot |
| deq_valid_o | output | 1 | Demand address available |
| deq_addr_o | output | ADDR_W | Oldest queued address |
| deq_ready_i | input | 1 | Cache takes the demand address |
| miss_pending_i | input | 1 | Cache has a miss outstanding |
| pf_valid_o | output | 1 | Lookahead address available for prefetch |
| pf_addr_o | output | ADDR_W | Address at the lookahead pointer |
| pf_ready_i | input | 1 | Prefetch engine takes the lookahead address |

## Verification
A corrupted demand or write pointer shows up at the demand port within one cycle. The demand address either skips, repeats or reorders, or `deq_valid_o` disagrees with the number of accepted entries. An off-by-one in the full comparison appears at `enq_ready_o` once the queue fills. After draining, it shows as one entry too many or too few.

A lookahead pointer that fails to stop at the write pointer exposes a stale address on the prefetch port. One that fails to snap forward after demand dequeues also exposes a stale address. Either shows on the first cycle `miss_pending_i` is raised. A flush that misses a valid bit leaves `deq_valid_o` high on the cycle after the flush.

// File: rtl/fq_pkg.sv
package fq_pkg;

    localparam int unsigned FQ_DEPTH_DEF  = 16;
    localparam int unsigned FQ_ADDR_W_DEF = 32;

    // Per-cycle events, already qualified by handshakes and flush priority
    typedef struct packed {
        logic flush;  // redirect: clear everything
        logic push;   // predictor address accepted
        logic pop;    // demand address taken by the cache
        logic peek;   // lookahead address taken by the prefetcher
    } fq_evt_t;

endpackage

// File: rtl/fq_ptr_ctrl.sv
module fq_ptr_ctrl
    import fq_pkg::*;
#(
    parameter int unsigned DEPTH = FQ_DEPTH_DEF,
    parameter int unsigned IDXW  = $clog2(DEPTH),
    parameter int unsigned PW    = IDXW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  fq_evt_t         evt,
    output logic [IDXW-1:0] wr_idx,
    output logic [IDXW-1:0] rd_idx,
    output logic [IDXW-1:0] pf_idx,
    output logic            full,
    output logic            empty,
    output logic            pf_avail
);

    localparam logic [PW-1:0] ONE     = PW'(1);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [PW-1:0] pf;
    } ptr_st_t;

    ptr_st_t       st_d, st_q;
    logic [PW-1:0] pf_step;
    logic [PW-1:0] pf_off_d;
    logic [PW-1:0] used_d;
    logic [PW-1:0] used_q;

    assign used_q = st_q.wr - st_q.rd;

    always_comb begin
        st_d     = st_q;
        pf_step  = st_q.pf;
        pf_off_d = '0;
        used_d   = '0;
        if (evt.flush) begin
            st_d = '0;
        end else begin
            if (evt.push) st_d.wr = st_q.wr + ONE;
            if (evt.pop)  st_d.rd = st_q.rd + ONE;
            if (evt.peek) pf_step = st_q.pf + ONE;
            // distance of the lookahead pointer from the new demand pointer;
            // a pointer left behind wraps to a value above the occupancy
            pf_off_d = pf_step - st_d.rd;
            used_d   = st_d.wr - st_d.rd;
            st_d.pf  = (pf_off_d > used_d) ? st_d.rd : pf_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_idx   = st_q.wr[IDXW-1:0];
    assign rd_idx   = st_q.rd[IDXW-1:0];
    assign pf_idx   = st_q.pf[IDXW-1:0];
    assign full     = (used_q == DEPTH_P);
    assign empty    = (used_q == '0);
    assign pf_avail = (st_q.pf != st_q.wr);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        used_q <= DEPTH_P); // R3

    AST_PF_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pf - st_q.rd) <= used_q); // R6

    AST_PF_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.pop && !evt.peek && !evt.flush && st_q.pf == st_q.rd)
        |=> (st_q.pf == st_q.rd)); // R7

    AST_FLUSH_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        evt.flush |=> (st_q.wr == st_q.rd) && (st_q.pf == st_q.rd)); // R8

endmodule

// File: rtl/fq_store.sv
module fq_store
    import fq_pkg::*;
#(
    parameter int unsigned DEPTH  = FQ_DEPTH_DEF,
    parameter int unsigned ADDR_W = FQ_ADDR_W_DEF,
    parameter int unsigned IDXW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fq_evt_t           evt,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [IDXW-1:0]   rd_idx,
    input  logic [IDXW-1:0]   pf_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_vld,
    output logic [ADDR_W-1:0] pf_addr
);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0]             vld;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (evt.flush) begin
            st_d.vld = '0;
        end else begin
            if (evt.push) begin
                st_d.addr[wr_idx] = wr_addr;
                st_d.vld[wr_idx]  = 1'b1;
            end
            if (evt.pop) begin
                st_d.vld[rd_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = st_q.addr[rd_idx];
    assign rd_vld  = st_q.vld[rd_idx];
    assign pf_addr = st_q.addr[pf_idx];

    AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
        evt.push |-> !st_q.vld[wr_idx]); // R3

    AST_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        evt.pop |-> st_q.vld[rd_idx]); // R2

endmodule

// File: rtl/decoupled_fetch_queue.sv
module decoupled_fetch_queue
    import fq_pkg::*;
#(
    parameter int unsigned DEPTH  = FQ_DEPTH_DEF,
    parameter int unsigned ADDR_W = FQ_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              enq_valid_i,
    input  logic [ADDR_W-1:0] enq_addr_i,
    output logic              enq_ready_o,
    output logic              deq_valid_o,
    output logic [ADDR_W-1:0] deq_addr_o,
    input  logic              deq_ready_i,
    input  logic              miss_pending_i,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_addr_o,
    input  logic              pf_ready_i
);

    localparam int unsigned IDXW = $clog2(DEPTH);
    localparam int unsigned PW   = IDXW + 1;

    fq_evt_t         evt;
    logic [IDXW-1:0] wr_idx, rd_idx, pf_idx;
    logic            full, empty, pf_avail;
    logic            head_vld;

    // Flush outranks every other event in the same cycle
    always_comb begin
        evt       = '0;
        evt.flush = flush_i;
        evt.push  = enq_valid_i && !full && !flush_i;
        evt.pop   = head_vld && deq_ready_i && !flush_i;
        evt.peek  = miss_pending_i && pf_avail && pf_ready_i && !flush_i;
    end

    assign enq_ready_o = !full;
    assign deq_valid_o = head_vld;
    assign pf_valid_o  = miss_pending_i && pf_avail;

    fq_ptr_ctrl #(
        .DEPTH (DEPTH),
        .IDXW  (IDXW),
        .PW    (PW)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .wr_idx   (wr_idx),
        .rd_idx   (rd_idx),
        .pf_idx   (pf_idx),
        .full     (full),
        .empty    (empty),
        .pf_avail (pf_avail)
    );

    fq_store #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W),
        .IDXW   (IDXW)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx),
        .pf_idx  (pf_idx),
        .wr_addr (enq_addr_i),
        .rd_addr (deq_addr_o),
        .rd_vld  (head_vld),
        .pf_addr (pf_addr_o)
    );

    AST_VALID_TRACKS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        head_vld == !empty); // R2

    AST_DEQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid_o && !deq_ready_i && !flush_i)
        |=> deq_valid_o && $stable(deq_addr_o)); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !deq_valid_o && enq_ready_o && !pf_valid_o); // R8

endmodule

// File: tb/decoupled_fetch_queue_tb.sv
`timescale 1ns/100ps
module decoupled_fetch_queue_tb;

    localparam int unsigned DEPTH  = 16;
    localparam int unsigned ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic              enq_valid_i = 1'b0;
    logic [ADDR_W-1:0] enq_addr_i = '0;
    logic              enq_ready_o;
    logic              deq_valid_o;
    logic [ADDR_W-1:0] deq_addr_o;
    logic              deq_ready_i = 1'b0;
    logic              miss_pending_i = 1'b0;
    logic              pf_valid_o;
    logic [ADDR_W-1:0] pf_addr_o;
    logic              pf_ready_i = 1'b0;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    decoupled_fetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .enq_valid_i(enq_valid_i), .enq_addr_i(enq_addr_i), .enq_ready_o(enq_ready_o),
        .deq_valid_o(deq_valid_o), .deq_addr_o(deq_addr_o), .deq_ready_i(deq_ready_i),
        .miss_pending_i(miss_pending_i),
        .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o), .pf_ready_i(pf_ready_i)
    );

    typedef struct packed {
        logic        fl;
        logic        ev;
        logic [31:0] ea;
        logic        dr;
        logic        ms;
        logic        pr;
        logic        x_rdy;
        logic        x_dv;
        logic [31:0] x_da;
        logic        x_pv;
        logic [31:0] x_pa;
        logic [7:0]  rq;
    } vec_t;

    // inputs for the cycle, and outputs expected in that cycle before the edge
    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,32'h000,1'b0,1'b0,1'b0, 1'b1,1'b0,32'h000,1'b0,32'h000, 8'd1}, // R1 idle
        '{1'b0,1'b1,32'h100,1'b0,1'b0,1'b0, 1'b1,1'b0,32'h000,1'b0,32'h000, 8'd4}, // R4 push A
        '{1'b0,1'b1,32'h140,1'b0,1'b0,1'b0, 1'b1,1'b1,32'h100,1'b0,32'h000, 8'd5}, // R5 no miss, no pf
        '{1'b0,1'b1,32'h180,1'b0,1'b1,1'b0, 1'b1,1'b1,32'h100,1'b1,32'h100, 8'd9}, // R9 head held
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b1, 1'b1,1'b1,32'h100,1'b1,32'h100, 8'd6}, // R6 pf take A
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b1, 1'b1,1'b1,32'h100,1'b1,32'h140, 8'd6}, // R6 pf take B
        '{1'b0,1'b0,32'h000,1'b1,1'b1,1'b0, 1'b1,1'b1,32'h100,1'b1,32'h180, 8'd6}, // R6 demand alone
        '{1'b0,1'b0,32'h000,1'b1,1'b0,1'b0, 1'b1,1'b1,32'h140,1'b0,32'h000, 8'd5}, // R5 miss low
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b1, 1'b1,1'b1,32'h180,1'b1,32'h180, 8'd6}, // R6 pf take C
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b1, 1'b1,1'b1,32'h180,1'b0,32'h000, 8'd6}, // R6 caught up
        '{1'b0,1'b1,32'h1c0,1'b0,1'b1,1'b0, 1'b1,1'b1,32'h180,1'b0,32'h000, 8'd6}, // R6 push D
        '{1'b0,1'b0,32'h000,1'b1,1'b1,1'b0, 1'b1,1'b1,32'h180,1'b1,32'h1c0, 8'd5}, // R5 D offered
        '{1'b0,1'b0,32'h000,1'b1,1'b1,1'b1, 1'b1,1'b1,32'h1c0,1'b1,32'h1c0, 8'd2}, // R2 both take D
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b0, 1'b1,1'b0,32'h000,1'b0,32'h000, 8'd2}, // R2 empty
        '{1'b0,1'b1,32'h200,1'b0,1'b0,1'b0, 1'b1,1'b0,32'h000,1'b0,32'h000, 8'd2}, // R2 push E
        '{1'b0,1'b1,32'h240,1'b0,1'b0,1'b0, 1'b1,1'b1,32'h200,1'b0,32'h000, 8'd2}, // R2 push F
        '{1'b0,1'b0,32'h000,1'b1,1'b0,1'b0, 1'b1,1'b1,32'h200,1'b0,32'h000, 8'd7}, // R7 pop E
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b0, 1'b1,1'b1,32'h240,1'b1,32'h240, 8'd7}, // R7 snapped
        '{1'b1,1'b1,32'h280,1'b1,1'b1,1'b0, 1'b1,1'b1,32'h240,1'b1,32'h240, 8'd8}, // R8 flush+push
        '{1'b0,1'b0,32'h000,1'b0,1'b1,1'b0, 1'b1,1'b0,32'h000,1'b0,32'h000, 8'd8}  // R8 emptied
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        flush_i = 1'b0; enq_valid_i = 1'b0; enq_addr_i = '0;
        deq_ready_i = 1'b0; miss_pending_i = 1'b0; pf_ready_i = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        string rq;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        miss_pending_i = 1'b1;
        #1;
        // R1: reset state with miss raised
        chk("R1", "enq_ready", 32'(enq_ready_o), 32'd1);
        chk("R1", "deq_valid", 32'(deq_valid_o), 32'd0);
        chk("R1", "pf_valid",  32'(pf_valid_o),  32'd0);
        step();

        for (int i = 0; i < NV; i++) begin
            flush_i        = VEC[i].fl;
            enq_valid_i    = VEC[i].ev;
            enq_addr_i     = VEC[i].ea;
            deq_ready_i    = VEC[i].dr;
            miss_pending_i = VEC[i].ms;
            pf_ready_i     = VEC[i].pr;
            #1;
            rq = $sformatf("R%0d", VEC[i].rq);
            chk(rq, $sformatf("v%0d enq_ready", i), 32'(enq_ready_o), 32'(VEC[i].x_rdy));
            chk(rq, $sformatf("v%0d deq_valid", i), 32'(deq_valid_o), 32'(VEC[i].x_dv));
            if (VEC[i].x_dv)
                chk(rq, $sformatf("v%0d deq_addr", i), deq_addr_o, VEC[i].x_da);
            chk(rq, $sformatf("v%0d pf_valid", i), 32'(pf_valid_o), 32'(VEC[i].x_pv));
            if (VEC[i].x_pv)
                chk(rq, $sformatf("v%0d pf_addr", i), pf_addr_o, VEC[i].x_pa);
            step();
        end
        idle_inputs();

        // R3 / R4: fill with demand stalled and a miss pending, one extra offer
        miss_pending_i = 1'b1;
        for (int i = 0; i <= DEPTH; i++) begin
            enq_valid_i = 1'b1;
            enq_addr_i  = 32'h1000 + 32'(i) * 4;
            #1;
            chk("R3", $sformatf("fill %0d enq_ready", i), 32'(enq_ready_o),
                (i < DEPTH) ? 32'd1 : 32'd0);
            step();
        end
        enq_valid_i = 1'b0;
        miss_pending_i = 1'b0;
        #1;
        chk("R3", "full after fill", 32'(enq_ready_o), 32'd0);
        chk("R4", "head after stalled fill", deq_addr_o, 32'h1000);

        // R2 / R3: drain in order, exactly DEPTH entries
        for (int i = 0; i < DEPTH; i++) begin
            deq_ready_i = 1'b1;
            #1;
            chk("R2", $sformatf("drain %0d valid", i), 32'(deq_valid_o), 32'd1);
            chk("R2", $sformatf("drain %0d addr", i), deq_addr_o, 32'h1000 + 32'(i) * 4);
            step();
        end
        deq_ready_i = 1'b0;
        #1;
        chk("R3", "dropped offer not stored", 32'(deq_valid_o), 32'd0);
        chk("R3", "ready after drain", 32'(enq_ready_o), 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule